// File: doc/BRIEF.md
# Wide-to-Narrow Write Command Translator

This block sits between a 64-bit host write port and a 32-bit PCI-style bus initiator. For each accepted host write request it works out one command descriptor: the bus address in the target window, the write command code, the number of 32-bit data beats, and the byte enables for the first two beats. Data buffering, bus signalling and reads are handled elsewhere. The block only plans the transfer.

The upper address bits are replaced by a fixed window base. The low address bits depend on the target space. Memory targets get linear-increment addressing. I/O targets keep the host's low byte address. A non-burst write becomes one 32-bit beat or two, depending on which halves of the double word carry enabled bytes. A burst write always moves full double words. A non-burst request with no enabled bytes is dropped and never reaches the initiator. The result is held in an output register with a valid/ready handshake.

Top module: `wr_cmd_xlate`

## Requirements
- R1: `cmd_addr_o[ADDR_W-1:ADDR_W-WIN_W]` equals the top `WIN_W` bits of `WIN_BASE`, and `cmd_addr_o[ADDR_W-WIN_W-1:3]` equals the same bits of the host address.
- R2: For a memory-space request (`req_io_i`=0), `cmd_addr_o[1:0]` is 2'b00.
- R3: For an I/O-space request (`req_io_i`=1), `cmd_addr_o[1:0]` equals `req_addr_i[1:0]`.
- R4: `cmd_code_o` is 4'b0011 for an I/O request and 4'b0111 for a memory request.
- R5: In a non-burst request, byte-enable bit i (active high) enables byte i, and bits 3:0 form the lower word. If only one word has enabled bytes, the command has `cmd_beats_o`=1 and `cmd_be1_o`=0. For the lower word, `cmd_be0_o`=`req_be_i[3:0]` and `cmd_addr_o[2]`=0. For the upper word, `cmd_be0_o`=`req_be_i[7:4]` and `cmd_addr_o[2]`=1.
- R6: If a non-burst request has enabled bytes in both words, the command has `cmd_beats_o`=2, `cmd_be0_o`=`req_be_i[3:0]`, `cmd_be1_o`=`req_be_i[7:4]` and `cmd_addr_o[2]`=0.
- R7: A burst request (`req_burst_i`=1) carries `req_len_i` = host beats minus one. It produces `cmd_beats_o` = 2*(`req_len_i`+1), `cmd_be0_o` = `cmd_be1_o` = 4'hF and `cmd_addr_o[2]`=0, whatever the byte enables are.
- R8: A non-burst request with `req_be_i`=0 produces no command. Instead, `drop_o` is high for exactly the cycle after acceptance.
- R9: A request is accepted at a clock edge where `req_valid_i` and `req_ready_o` are both high. `cmd_valid_o` rises in the next cycle. While `cmd_valid_o` is high and `cmd_ready_i` is low, the command stays unchanged and `req_ready_o` is low.
- R10: After reset, `cmd_valid_o` and `drop_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host write request present |
| req_ready_o | output | 1 | Translator can accept a request |
| req_addr_i | input | ADDR_W | Host byte address |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_be_i | input | 8 | Host byte enables, active high |
| req_burst_i | input | 1 | Burst-qualified request |
| req_len_i | input | LEN_W | Host burst beats minus one |
| cmd_valid_o | output | 1 | Command descriptor valid |
| cmd_ready_i | input | 1 | Initiator takes the descriptor |
| cmd_addr_o | output | ADDR_W | Translated bus address |
| cmd_code_o | output | 4 | Bus write command code |
| cmd_beats_o | output | LEN_W+2 | Number of 32-bit beats |
| cmd_be0_o | output | 4 | Byte enables of beat 0 |
| cmd_be1_o | output | 4 | Byte enables of beat 1 |
| drop_o | output | 1 | Pulse: request had no enabled bytes |

## Verification
A wrong half-word decision shows up one cycle after acceptance. It appears together in the beat count, in address bit 2 and in which byte-enable lane carries the mask, so each single-beat and two-beat pattern is checked on all three. If the held descriptor is overwritten or the ready path is wrong, the command changes during a stall. This is visible in the cycle after a second request is offered against a held command. A wrong drop decision shows up as either a spurious `cmd_valid_o` or a missing `drop_o` pulse in that same cycle.

// File: rtl/wcx_pkg.sv
package wcx_pkg;
  localparam logic [3:0] CODE_IO_WR  = 4'b0011;
  localparam logic [3:0] CODE_MEM_WR = 4'b0111;
endpackage

// File: rtl/wcx_addr_map.sv
module wcx_addr_map #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              io_i,
  input  logic              word_hi_i,
  output logic [ADDR_W-1:0] bus_addr_o
);
  localparam int unsigned OFF_W = ADDR_W - WIN_W;

  logic [OFF_W-1:0] offset;

  always_comb begin
    offset      = host_addr_i[OFF_W-1:0];
    offset[2]   = word_hi_i;
    offset[1:0] = io_i ? host_addr_i[1:0] : 2'b00;
  end

  generate
    if (WIN_W == 0) begin : g_flat
      assign bus_addr_o = offset;
    end else begin : g_win
      assign bus_addr_o = {WIN_BASE[ADDR_W-1:OFF_W], offset};
    end
  endgenerate
endmodule

// File: rtl/wcx_beat_plan.sv
module wcx_beat_plan #(
  parameter int unsigned LEN_W = 5,
  localparam int unsigned BEAT_W = LEN_W + 2
) (
  input  logic [7:0]        be_i,
  input  logic              burst_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              ok_o,
  output logic              word_hi_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic [3:0]        be0_o,
  output logic [3:0]        be1_o
);
  logic lo_any, hi_any;
  assign lo_any = |be_i[3:0];
  assign hi_any = |be_i[7:4];

  always_comb begin
    ok_o      = 1'b1;
    word_hi_o = 1'b0;
    beats_o   = '0;
    be0_o     = 4'h0;
    be1_o     = 4'h0;
    if (burst_i) begin
      // every host data phase is a full double word
      beats_o = {1'b0, len_i, 1'b0} + BEAT_W'(2);
      be0_o   = 4'hF;
      be1_o   = 4'hF;
    end else if (lo_any && hi_any) begin
      beats_o = BEAT_W'(2);
      be0_o   = be_i[3:0];
      be1_o   = be_i[7:4];
    end else if (hi_any) begin
      beats_o   = BEAT_W'(1);
      word_hi_o = 1'b1;
      be0_o     = be_i[7:4];
    end else if (lo_any) begin
      beats_o = BEAT_W'(1);
      be0_o   = be_i[3:0];
    end else begin
      ok_o = 1'b0;
    end
  end
endmodule

// File: rtl/wr_cmd_xlate.sv
module wr_cmd_xlate
  import wcx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hC000_0000,
  parameter int unsigned LEN_W  = 5,
  localparam int unsigned BEAT_W = LEN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_io_i,
  input  logic [7:0]        req_be_i,
  input  logic              req_burst_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [3:0]        cmd_code_o,
  output logic [BEAT_W-1:0] cmd_beats_o,
  output logic [3:0]        cmd_be0_o,
  output logic [3:0]        cmd_be1_o,
  output logic              drop_o
);
  logic              ok, word_hi, acc;
  logic [BEAT_W-1:0] beats;
  logic [3:0]        be0, be1;
  logic [ADDR_W-1:0] bus_addr;

  wcx_beat_plan #(.LEN_W(LEN_W)) u_plan (
    .be_i(req_be_i), .burst_i(req_burst_i), .len_i(req_len_i),
    .ok_o(ok), .word_hi_o(word_hi), .beats_o(beats),
    .be0_o(be0), .be1_o(be1)
  );

  wcx_addr_map #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .WIN_BASE(WIN_BASE)) u_map (
    .host_addr_i(req_addr_i), .io_i(req_io_i), .word_hi_i(word_hi),
    .bus_addr_o(bus_addr)
  );

  assign req_ready_o = !cmd_valid_o || cmd_ready_i;
  assign acc         = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      drop_o      <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_code_o  <= 4'h0;
      cmd_beats_o <= '0;
      cmd_be0_o   <= 4'h0;
      cmd_be1_o   <= 4'h0;
    end else begin
      drop_o <= acc && !ok;
      if (acc) begin
        cmd_valid_o <= ok;
        if (ok) begin
          cmd_addr_o  <= bus_addr;
          cmd_code_o  <= req_io_i ? CODE_IO_WR : CODE_MEM_WR;
          cmd_beats_o <= beats;
          cmd_be0_o   <= be0;
          cmd_be1_o   <= be1;
        end
      end else if (cmd_ready_i) begin
        cmd_valid_o <= 1'b0;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o)
      && $stable(cmd_beats_o) && $stable(cmd_be0_o) && $stable(cmd_be1_o));
  assert_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ok |=> cmd_valid_o);
  assert_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !ok |=> drop_o && !cmd_valid_o);
  assert_mem_lsb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ok && !req_io_i |=> cmd_addr_o[1:0] == 2'b00);
  assert_burst_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_burst_i |=> cmd_beats_o == BEAT_W'(2 * ($past(req_len_i) + 1)));
  assert_io_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ok && req_io_i |=> cmd_code_o == CODE_IO_WR);
endmodule

// File: tb/wr_cmd_xlate_test.sv
module wr_cmd_xlate_test;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LEN_W = 5;
  localparam int unsigned BEAT_W = LEN_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_io = 1'b0, req_burst = 1'b0, cmd_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_be = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, cmd_valid, drop;
  logic [ADDR_W-1:0] cmd_addr;
  logic [3:0] cmd_code, be0, be1;
  logic [BEAT_W-1:0] beats;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wr_cmd_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_io_i(req_io), .req_be_i(req_be),
    .req_burst_i(req_burst), .req_len_i(req_len), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr), .cmd_code_o(cmd_code),
    .cmd_beats_o(beats), .cmd_be0_o(be0), .cmd_be1_o(be1), .drop_o(drop)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] a, logic io, logic hi);
    return {8'hC0, a[23:3], hi, io ? a[1:0] : 2'b00};
  endfunction

  task automatic send(logic [31:0] a, logic io, logic [7:0] be, logic bu, logic [LEN_W-1:0] ln);
    @(negedge clk);
    req_addr = a; req_io = io; req_be = be; req_burst = bu; req_len = ln;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 valid", cmd_valid, 0);
    check("R10 drop", drop, 0);
    check("R10 ready", req_ready, 1);
  endtask

  task automatic t_single_lo();
    send(32'h1234_5677, 1'b0, 8'h06, 1'b0, '0);
    check("R9 valid", cmd_valid, 1);
    check("R1 R2 R5 addr", cmd_addr, exp_addr(32'h1234_5677, 0, 0));
    check("R4 mem code", cmd_code, 4'b0111);
    check("R5 beats", beats, 1);
    check("R5 be0", be0, 4'h6);
    check("R5 be1", be1, 0);
  endtask

  task automatic t_single_hi_io();
    send(32'h0000_1A0B, 1'b1, 8'h80, 1'b0, '0);
    check("R3 R5 addr", cmd_addr, exp_addr(32'h0000_1A0B, 1, 1));
    check("R4 io code", cmd_code, 4'b0011);
    check("R5 beats hi", beats, 1);
    check("R5 be0 hi", be0, 4'h8);
    check("R5 be1 hi", be1, 0);
  endtask

  task automatic t_double();
    send(32'hFFFF_FFF0, 1'b0, 8'h3C, 1'b0, '0);
    check("R6 addr", cmd_addr, exp_addr(32'hFFFF_FFF0, 0, 0));
    check("R6 beats", beats, 2);
    check("R6 be0", be0, 4'hC);
    check("R6 be1", be1, 4'h3);
  endtask

  task automatic t_burst();
    send(32'h0040_0008, 1'b0, 8'h00, 1'b1, 5'd7);
    check("R7 valid", cmd_valid, 1);
    check("R7 beats", beats, 16);
    check("R7 be", {be1, be0}, 8'hFF);
    check("R7 addr", cmd_addr, exp_addr(32'h0040_0008, 0, 0));
    send(32'h0040_0010, 1'b1, 8'h01, 1'b1, 5'd31);
    check("R7 beats max", beats, 64);
  endtask

  task automatic t_drop();
    send(32'h0000_0100, 1'b0, 8'h00, 1'b0, '0);
    check("R8 drop", drop, 1);
    check("R8 no cmd", cmd_valid, 0);
    @(negedge clk);
    check("R8 pulse", drop, 0);
  endtask

  task automatic t_stall();
    cmd_ready = 1'b0;
    send(32'h0000_0200, 1'b0, 8'h0F, 1'b0, '0);
    check("R9 held valid", cmd_valid, 1);
    check("R9 ready low", req_ready, 0);
    req_addr = 32'h0000_0304; req_io = 1'b1; req_be = 8'hF0; req_burst = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    check("R9 held addr", cmd_addr, exp_addr(32'h0000_0200, 0, 0));
    check("R9 held be", be0, 4'hF);
    cmd_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next valid", cmd_valid, 1);
    check("R9 next addr", cmd_addr, exp_addr(32'h0000_0304, 1, 1));
    @(negedge clk);
    check("R9 drained", cmd_valid, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_lo();
    t_single_hi_io();
    t_double();
    t_burst();
    t_drop();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule